// File: doc/BRIEF.md
# Strided Vector Move/Swap Engine

This block copies one strided vector of floating-point elements onto another, or exchanges the contents of two such vectors, without touching the element values. A single start command carries everything it needs: the first and second base word addresses, a signed element stride for each, a signed element count, a precision select (two-word or four-word elements) and a copy/exchange select. The engine then walks both vectors one element at a time through a single-port word memory and pulses done when the last element has been handled.

All memory traffic goes through one request/ready port with at most one access in flight. Each element is staged in full in local word buffers before anything is written back. Because of this, vectors that overlap, or a stride of zero, give the same result as a plain element-by-element loop run in software.

Top module: `vec_xfer_engine`

## Requirements
- R1: After reset, busy, done and mem_req are all low, and no memory request is made while busy is low.
- R2: A start with a count of zero or less (16-bit two's complement) makes no memory request. done goes high in the cycle right after the start cycle.
- R3: cmd_dbl = 1 selects 4-word elements and cmd_dbl = 0 selects 2-word elements. The words of one element are accessed at base, base+1, and so on in ascending order, so an element takes exactly 3 accesses per word in copy mode and 4 in exchange mode.
- R4: For every element, the engine first reads every word of the first vector's element and then every word of the second vector's element. It then writes the first element's words to the second address. In copy mode (cmd_swap = 0) it never writes the first vector.
- R5: In exchange mode (cmd_swap = 1), after the second-vector writes the engine writes the originally read second-vector words to the first vector's element.
- R6: After each element, each address advances by its signed stride times the element width in words (2 or 4). Negative and zero strides are allowed.
- R7: Every word address, including base+offset inside an element, wraps modulo 2^15.
- R8: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R9: done is high for exactly one cycle, in the cycle after the final write is accepted. busy is high from the cycle after start until done and low in the cycle after done.
- R10: A start received while busy is high has no effect on the running sequence's accesses or its single done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted only while idle |
| cmd_base_a | input | 15 | First vector base word address |
| cmd_base_b | input | 15 | Second vector base word address |
| cmd_stride_a | input | 16 | First vector signed element stride |
| cmd_stride_b | input | 16 | Second vector signed element stride |
| cmd_count | input | 16 | Signed element count |
| cmd_dbl | input | 1 | 1: four-word elements, 0: two-word elements |
| cmd_swap | input | 1 | 1: exchange, 0: copy |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The embedded properties watch the handshake holding stable under back-pressure, the single-cycle done, the immediate completion of a non-positive count, and the silence of the memory port while idle. They also check that a start during a run freezes nothing it should not, and that first-vector writes occur only in exchange mode. The order and values of the accesses can only be judged against a full run, which is why the bench scenarios are needed. These include stride scaling by precision, address wrap, read-before-write on overlapping vectors, and the data actually exchanged. The bench replays every command on its own sequential model of memory and compares the complete access trace under randomly stalled ready.

// File: rtl/vxe_pkg.sv
package vxe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_RD_B = 3'd2,
    ST_WR_B = 3'd3,
    ST_WR_A = 3'd4,
    ST_FIN  = 3'd5
  } vxe_state_e;

  // Last word index of an element for the chosen precision.
  function automatic logic [1:0] last_word_idx(input logic dbl);
    return dbl ? 2'd3 : 2'd1;
  endfunction

  // log2 of element width in words.
  function automatic int unsigned width_shift(input logic dbl);
    return dbl ? 2 : 1;
  endfunction

endpackage

// File: rtl/vxe_ptr.sv
module vxe_ptr #(
  parameter int ADDR_W   = 15,
  parameter int STRIDE_W = 16,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                dbl,
  input  logic                advance,
  input  logic [IDX_W-1:0]    word_idx,
  output logic [ADDR_W-1:0]   word_addr
);
  import vxe_pkg::*;

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] step_q;

  // Signed element stride scaled to words, reduced modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] scale_stride(input logic [STRIDE_W-1:0] s,
                                                     input logic d);
    logic signed [31:0] wide;
    wide = 32'($signed(s));
    return ADDR_W'(wide <<< width_shift(d));
  endfunction

  function automatic logic [ADDR_W-1:0] offset_addr(input logic [ADDR_W-1:0] p,
                                                    input logic [IDX_W-1:0] k);
    return p + ADDR_W'(k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      ptr_q  <= base;
      step_q <= scale_stride(stride, dbl);
    end else if (advance) begin
      ptr_q  <= ptr_q + step_q;
    end
  end

  assign word_addr = offset_addr(ptr_q, word_idx);

  // R10: the pointer only moves on a load or an element advance.
  p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(ptr_q));

endmodule

// File: rtl/vxe_wbuf.sv
module vxe_wbuf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/vxe_seq.sv
module vxe_seq #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     count,
  input  logic                 dbl,
  input  logic                 swap,
  input  logic                 mem_ready,
  output vxe_pkg::vxe_state_e  state,
  output logic [IDX_W-1:0]     word_idx,
  output logic                 dbl_r,
  output logic                 swap_r,
  output logic                 load,
  output logic                 advance,
  output logic                 hs,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 busy,
  output logic                 done
);
  import vxe_pkg::*;

  vxe_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q;
  logic [IDX_W-1:0] widx_q;
  logic             last_word;
  logic             last_elem;
  logic             nonpos;

  function automatic logic is_nonpos(input logic [CNT_W-1:0] c);
    return c[CNT_W-1] || (c == '0);
  endfunction

  assign nonpos    = is_nonpos(count);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign load      = start && !busy;
  assign mem_req   = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                     (state_q == ST_WR_B) || (state_q == ST_WR_A);
  assign mem_we    = (state_q == ST_WR_B) || (state_q == ST_WR_A);
  assign hs        = mem_req && mem_ready;
  assign last_word = (widx_q == IDX_W'(last_word_idx(dbl_r)));
  assign last_elem = (left_q == CNT_W'(1));
  assign advance   = hs && last_word &&
                     ((state_q == ST_WR_A) || (state_q == ST_WR_B && !swap_r));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = nonpos ? ST_FIN : ST_RD_A;
      ST_RD_A: if (hs && last_word) state_d = ST_RD_B;
      ST_RD_B: if (hs && last_word) state_d = ST_WR_B;
      ST_WR_B: if (hs && last_word)
                 state_d = swap_r ? ST_WR_A : (last_elem ? ST_FIN : ST_RD_A);
      ST_WR_A: if (hs && last_word) state_d = last_elem ? ST_FIN : ST_RD_A;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      widx_q  <= '0;
      dbl_r   <= 1'b0;
      swap_r  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        left_q <= count;
        widx_q <= '0;
        dbl_r  <= dbl;
        swap_r <= swap;
      end else begin
        if (advance) left_q <= left_q - CNT_W'(1);
        if (hs) widx_q <= last_word ? '0 : widx_q + IDX_W'(1);
      end
    end
  end

  assign state    = state_q;
  assign word_idx = widx_q;

  // R1: an idle engine issues no memory request.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R2: a non-positive count completes in the following cycle.
  p_nonpos_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && nonpos) |=> (done && !mem_req));

  // R3: the word index never passes the element width.
  p_word_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (widx_q <= IDX_W'(last_word_idx(dbl_r))));

  // R9: done lasts a single cycle and is followed by idle.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10: a start during a run leaves the sequence untouched.
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !hs && !done) |=> ($stable(state_q) && $stable(widx_q) && $stable(left_q)));

endmodule

// File: rtl/vec_xfer_engine.sv
module vec_xfer_engine #(
  parameter int ADDR_W    = 15,
  parameter int WORD_W    = 16,
  parameter int STRIDE_W  = 16,
  parameter int CNT_W     = 16,
  parameter int MAX_WORDS = 4,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int NPTR     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   cmd_base_a,
  input  logic [ADDR_W-1:0]   cmd_base_b,
  input  logic [STRIDE_W-1:0] cmd_stride_a,
  input  logic [STRIDE_W-1:0] cmd_stride_b,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic                cmd_dbl,
  input  logic                cmd_swap,
  output logic                busy,
  output logic                done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ready,
  input  logic [WORD_W-1:0]   mem_rdata
);
  import vxe_pkg::*;

  vxe_state_e        state;
  logic [IDX_W-1:0]  word_idx;
  logic              dbl_r, swap_r, load, advance, hs;
  logic [ADDR_W-1:0]   base_v   [NPTR];
  logic [STRIDE_W-1:0] stride_v [NPTR];
  logic [ADDR_W-1:0]   waddr_v  [NPTR];
  logic [WORD_W-1:0]   held_v   [NPTR];
  logic                cap_v    [NPTR];

  assign base_v[0]   = cmd_base_a;
  assign base_v[1]   = cmd_base_b;
  assign stride_v[0] = cmd_stride_a;
  assign stride_v[1] = cmd_stride_b;
  assign cap_v[0]    = hs && (state == ST_RD_A);
  assign cap_v[1]    = hs && (state == ST_RD_B);

  vxe_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count    (cmd_count),
    .dbl      (cmd_dbl),
    .swap     (cmd_swap),
    .mem_ready(mem_ready),
    .state    (state),
    .word_idx (word_idx),
    .dbl_r    (dbl_r),
    .swap_r   (swap_r),
    .load     (load),
    .advance  (advance),
    .hs       (hs),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .busy     (busy),
    .done     (done)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_lane
    vxe_ptr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .IDX_W(IDX_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .base     (base_v[g]),
      .stride   (stride_v[g]),
      .dbl      (cmd_dbl),
      .advance  (advance),
      .word_idx (word_idx),
      .word_addr(waddr_v[g])
    );

    vxe_wbuf #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cap_v[g]),
      .wr_idx (word_idx),
      .wr_data(mem_rdata),
      .rd_idx (word_idx),
      .rd_data(held_v[g])
    );
  end

  // Lane A addresses the RD_A and WR_A phases, lane B the others.
  assign mem_addr  = ((state == ST_RD_A) || (state == ST_WR_A)) ? waddr_v[0] : waddr_v[1];
  // Lane B receives lane A's element; lane A receives lane B's.
  assign mem_wdata = (state == ST_WR_B) ? held_v[0] : held_v[1];

  // R8: a stalled request holds every field.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5: the first vector is written only in exchange mode.
  p_wr_a_swap_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == waddr_v[0] && state == ST_WR_A) |-> swap_r);

  // R4: a write follows the reads of the same element.
  p_write_after_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $rose(mem_we)) |-> $past(state == ST_RD_B));

endmodule

// File: tb/vec_xfer_engine_tb.sv
module vec_xfer_engine_tb;

  localparam int MASK = 32'h7FFF;

  typedef struct packed {
    bit          we;
    int          addr;
    logic [15:0] data;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] cmd_base_a = '0, cmd_base_b = '0;
  logic [15:0] cmd_stride_a = '0, cmd_stride_b = '0, cmd_count = '0;
  logic        cmd_dbl = 1'b0, cmd_swap = 1'b0;
  logic        busy, done, mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int hold_err = 0;

  logic [15:0] dut_mem [int];
  logic [15:0] ref_mem [int];
  acc_t act_q [$];
  acc_t exp_q [$];

  always #10 clk = ~clk;

  vec_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_base_a(cmd_base_a), .cmd_base_b(cmd_base_b),
    .cmd_stride_a(cmd_stride_a), .cmd_stride_b(cmd_stride_b),
    .cmd_count(cmd_count), .cmd_dbl(cmd_dbl), .cmd_swap(cmd_swap),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] seed_val(int a);
    return 16'((a * 40503) ^ 16'h5A3C);
  endfunction

  function automatic logic [15:0] rd_dut(int a);
    return dut_mem.exists(a) ? dut_mem[a] : seed_val(a);
  endfunction

  function automatic logic [15:0] rd_ref(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Memory responder: decides ready for the coming edge and services it.
  initial begin
    logic [7:0] lfsr = 8'hB7;
    logic       pend = 1'b0;
    acc_t       held;
    forever begin
      @(negedge clk);
      if (pend) begin
        if (!(mem_req && mem_addr == held.addr[14:0] && mem_we == held.we &&
              (!held.we || mem_wdata == held.data)))
          hold_err++;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[2];
      pend = mem_req && !mem_ready;
      held.we = mem_we;
      held.addr = int'(mem_addr);
      held.data = mem_wdata;
      if (mem_req && mem_ready) begin
        acc_t e;
        e.we = mem_we;
        e.addr = int'(mem_addr);
        if (mem_we) begin
          e.data = mem_wdata;
          dut_mem[int'(mem_addr)] = mem_wdata;
        end else begin
          e.data = rd_dut(int'(mem_addr));
          mem_rdata = e.data;
        end
        act_q.push_back(e);
      end
    end
  end

  // Sequential reference of one command.
  task automatic model(int ba, int bb, int sa, int sb, int n, bit dbl, bit swp);
    int w = dbl ? 4 : 2;
    int a = ba;
    int b = bb;
    for (int e = 0; e < n; e++) begin
      logic [15:0] va [4];
      logic [15:0] vb [4];
      acc_t x;
      for (int k = 0; k < w; k++) begin
        x.we = 0; x.addr = (a + k) & MASK; x.data = rd_ref(x.addr);
        va[k] = x.data; exp_q.push_back(x);
      end
      for (int k = 0; k < w; k++) begin
        x.we = 0; x.addr = (b + k) & MASK; x.data = rd_ref(x.addr);
        vb[k] = x.data; exp_q.push_back(x);
      end
      for (int k = 0; k < w; k++) begin
        x.we = 1; x.addr = (b + k) & MASK; x.data = va[k];
        ref_mem[x.addr] = va[k]; exp_q.push_back(x);
      end
      if (swp) begin
        for (int k = 0; k < w; k++) begin
          x.we = 1; x.addr = (a + k) & MASK; x.data = vb[k];
          ref_mem[x.addr] = vb[k]; exp_q.push_back(x);
        end
      end
      a = (a + sa * w) & MASK;
      b = (b + sb * w) & MASK;
    end
  endtask

  task automatic run_cmd(int ba, int bb, int sa, int sb, int n, bit dbl, bit swp, bit glitch);
    int w = dbl ? 4 : 2;
    int per = w * (swp ? 4 : 3);
    int cycles = 0;
    int mism = 0;
    int first_bad = -1;
    act_q.delete();
    exp_q.delete();
    ref_mem = dut_mem;
    model(ba, bb, sa, sb, n, dbl, swp);
    hold_err = 0;
    @(negedge clk);
    cmd_base_a = 15'(ba); cmd_base_b = 15'(bb);
    cmd_stride_a = 16'(sa); cmd_stride_b = 16'(sb);
    cmd_count = 16'(n); cmd_dbl = dbl; cmd_swap = swp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n <= 0) check(done === 1'b1, "R2", "done one cycle after start", int'(done), 1);
    while (done !== 1'b1 && cycles < 5000) begin
      if (glitch && cycles == 3) begin
        check(busy === 1'b1, "R9", "busy during run", int'(busy), 1);
        cmd_base_a = 15'(ba + 500); cmd_base_b = 15'(bb + 900);
        cmd_stride_a = 16'(7); cmd_count = 16'(-1); cmd_swap = ~swp; cmd_dbl = ~dbl;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check(done === 1'b1, "R9", "done reached", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done single pulse then idle",
          int'({done, busy}), 0);
    check(act_q.size() == exp_q.size(), "R3", "access count", act_q.size(), exp_q.size());
    for (int i = 0; i < act_q.size() && i < exp_q.size(); i++) begin
      if (act_q[i] != exp_q[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (glitch)
      check(mism == 0, "R10", "trace with start while busy", first_bad, -1);
    else
      check(mism == 0, swp ? "R5" : "R4", "trace mismatch index", first_bad, -1);
    check(hold_err == 0, "R8", "request held under stall", hold_err, 0);
    if (n <= 0) check(act_q.size() == 0, "R2", "no access for count<=0", act_q.size(), 0);
    if (n >= 1 && act_q.size() >= w) begin
      for (int k = 0; k < w; k++)
        check(act_q[k].addr == ((ba + k) & MASK), "R3", "ascending word address",
              act_q[k].addr, (ba + k) & MASK);
    end
    if (n >= 2 && act_q.size() > per + w) begin
      check(act_q[per].addr == ((ba + sa * w) & MASK), "R6", "second A element address",
            act_q[per].addr, (ba + sa * w) & MASK);
      check(act_q[per + w].addr == ((bb + sb * w) & MASK), "R6", "second B element address",
            act_q[per + w].addr, (bb + sb * w) & MASK);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt_set [4] = '{-1, 0, 1, 3};
    int sa_set  [4] = '{-2, 0, 1, 3};
    int sb_set  [3] = '{-1, 1, 2};
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1", "reset outputs",
          int'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req === 1'b0, "R1", "idle after reset", int'(mem_req), 0);

    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int ci = 0; ci < 4; ci++)
          for (int ai = 0; ai < 4; ai++)
            for (int bi = 0; bi < 3; bi++)
              run_cmd(1000 + 40 * ai, 1006 + 40 * ai, sa_set[ai], sb_set[bi],
                      cnt_set[ci], d[0], s[0], 1'b0);

    // Large negative count.
    run_cmd(300, 400, 1, 1, -32768, 1'b1, 1'b1, 1'b0);
    // R7: wrap at the top of the address space, both directions.
    run_cmd(32766, 2, 1, -1, 3, 1'b1, 1'b0, 1'b0);
    check(act_q.size() > 2 && act_q[2].addr == 0, "R7", "wrap inside element",
          act_q.size() > 2 ? act_q[2].addr : -1, 0);
    run_cmd(32765, 1, 1, -1, 2, 1'b0, 1'b1, 1'b0);
    check(act_q.size() > 2 && act_q[2].addr == 1, "R7", "B base word", act_q[2].addr, 1);
    // R6: same vector exchanged with itself shifted by one element.
    run_cmd(2000, 2004, 2, 2, 4, 1'b1, 1'b1, 1'b0);
    // R10: start pulsed while busy.
    run_cmd(3000, 3100, 1, -1, 3, 1'b1, 1'b1, 1'b1);
    run_cmd(3200, 3300, 2, 1, 2, 1'b0, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule